// File: doc/BRIEF.md
# Sixteen-Bit Register Machine Core

This block is a small single-issue processor core. Each cycle in which it is allowed to run, it fetches one 16-bit word from a 32-entry program store, decodes the 4-bit operation code in the top nibble, and executes it against sixteen 16-bit general registers. The supported operations are: load a small constant, add, subtract, copy a register to an output port, jump when a register is zero, and jump always. Every other code is a no-operation.

The program store has a plain write port, so a host can fill it before the core is started, or while the core is running. The core sits at address 0 until `run` goes high and pauses whenever `run` is low. Output instructions update registered ports; port 0 also drives the value for a numeric display. Once the word at the highest store address has executed, the core stops until the next reset.

Top module: `nib_core`

## Requirements
- R1: Instruction layout: word[15:12] is the operation code, word[11:8] is register field A, word[7:4] is register field B, and word[3:0] is a 4-bit constant K. One instruction completes per clock edge while running, and a register result is visible to the very next instruction. Code 0x2 writes K, zero-extended to 16 bits, into register A; no bits of the old value survive.
- R2: Code 0x1 writes A + B (modulo 2^16) into register A.
- R3: Code 0x3 writes A - B (modulo 2^16) into register A, so 0 - 1 gives 0xFFFF.
- R4: Code 0xC copies register A into output port number B and writes no register. Ports 0 to 3 exist, and a B value of 4 or more changes no port. `port_bus[16*i +: 16]` is port i, and `disp_value` equals port 0.
- R5: Code 0xD loads the program counter with K when register A is zero. Otherwise execution falls through to the next address.
- R6: Code 0xF always loads the program counter with K.
- R7: Reset clears the program counter, all registers and all ports to zero. Program store contents survive reset.
- R8: Execution starts at address 0. While `run` is low, no instruction executes and no state changes.
- R9: The word at address 31 executes once. The core then stops, and its ports stay constant until reset.
- R10: Codes 0x0, 0x4 to 0xB and 0xE act as no-operations: no register write, no port write, and the counter advances by one.
- R11: A store write to the address being executed in the same cycle does not affect that execution. The old word runs, and the new word is used from the next fetch onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute one instruction per cycle while high |
| pgm_we | input | 1 | Program store write strobe |
| pgm_addr | input | 5 | Program store write address |
| pgm_data | input | 16 | Program store write word |
| disp_value | output | 16 | Display value (copy of port 0) |
| port_bus | output | 64 | Four 16-bit output ports, port i at bits [16*i+15:16*i] |

## Verification
Two functions can fall in the same cycle: a host write to the program store, and execution of the word at that same address. The bench provokes this by raising `run` and writing a new constant-load word to address 0 in the same cycle. It then judges the outcome through the count-up sequence on the display: the first pass must show the old constant, and a rerun after reset must show the new one. It also runs a count-down program through to the stopping address and a port/wrap program. Expected display values are derived arithmetically from the cycle count.

// File: rtl/nib_pkg.sv
package nib_pkg;

   localparam int OP_W   = 4;
   localparam int RSEL_W = 4;
   localparam int K_W    = 4;
   localparam int WORD_W = OP_W + 2 * RSEL_W + K_W;

   localparam logic [OP_W-1:0] OPC_ADD  = 4'h1;
   localparam logic [OP_W-1:0] OPC_LDK  = 4'h2;
   localparam logic [OP_W-1:0] OPC_SUB  = 4'h3;
   localparam logic [OP_W-1:0] OPC_PUT  = 4'hC;
   localparam logic [OP_W-1:0] OPC_BRZ  = 4'hD;
   localparam logic [OP_W-1:0] OPC_GOTO = 4'hF;

   typedef enum logic [1:0] {
      FN_ADD   = 2'd0,
      FN_SUB   = 2'd1,
      FN_CONST = 2'd2
   } fn_e;

   typedef struct packed {
      logic reg_we;
      fn_e  fn;
      logic port_we;
      logic br_zero;
      logic br_always;
   } ctl_t;

   function automatic ctl_t decode_op(input logic [OP_W-1:0] op);
      ctl_t c;
      c = '{reg_we: 1'b0, fn: FN_ADD, port_we: 1'b0, br_zero: 1'b0, br_always: 1'b0};
      case (op)
         OPC_ADD:  begin c.reg_we = 1'b1; c.fn = FN_ADD;   end
         OPC_SUB:  begin c.reg_we = 1'b1; c.fn = FN_SUB;   end
         OPC_LDK:  begin c.reg_we = 1'b1; c.fn = FN_CONST; end
         OPC_PUT:  c.port_we   = 1'b1;
         OPC_BRZ:  c.br_zero   = 1'b1;
         OPC_GOTO: c.br_always = 1'b1;
         default:  ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/nib_store.sv
module nib_store #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 32,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // asynchronous read: the word executed this cycle is the pre-edge content
   assign rdata = mem[raddr];

   assert_store_write_R11: assert property (@(posedge clk)
      we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
   parameter int DW        = 16,
   parameter int NREG      = 16,
   parameter bit CLEAR_RST = 1'b1,
   localparam int SW       = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [SW-1:0] addr_a,
   input  logic [SW-1:0] addr_b,
   output logic [DW-1:0] data_a,
   output logic [DW-1:0] data_b
);

   logic [DW-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (CLEAR_RST) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q[i] <= '0;
            else if (we && waddr == SW'(i))      q[i] <= wdata;
         end
      end else begin : g_keep
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we && waddr == SW'(i)) q[i] <= wdata;
         end
      end

      // R10: an entry not addressed by a write keeps its value
      assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && waddr == SW'(i)) |=> $stable(q[i]));
   end

   assign data_a = q[addr_a];
   assign data_b = q[addr_b];

endmodule

// File: rtl/nib_alu.sv
module nib_alu
   import nib_pkg::*;
#(
   parameter int DW = 16,
   parameter int KW = 4
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [KW-1:0] k,
   input  fn_e           fn,
   output logic [DW-1:0] result,
   output logic          a_zero
);

   always_comb begin
      case (fn)
         FN_SUB:   result = a - b;
         FN_CONST: result = DW'(k);
         default:  result = a + b;
      endcase
   end

   assign a_zero = (a == '0);

endmodule

// File: rtl/nib_ports.sv
module nib_ports #(
   parameter int DW     = 16,
   parameter int NPORTS = 4,
   parameter int SELW   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [SELW-1:0]    sel,
   input  logic [DW-1:0]      data,
   output logic [NPORTS*DW-1:0] bus
);

   logic [DW-1:0] q [NPORTS];

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       q[i] <= '0;
         else if (we && sel == SELW'(i))   q[i] <= data;
      end
      assign bus[i*DW +: DW] = q[i];

      // R4: a port not selected by a write keeps its value
      assert_port_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && sel == SELW'(i)) |=> $stable(q[i]));
   end

endmodule

// File: rtl/nib_core.sv
module nib_core
   import nib_pkg::*;
#(
   parameter int  DW        = 16,
   parameter int  DEPTH     = 32,
   parameter int  NPORTS    = 4,
   parameter bit  CLEAR_RST = 1'b1,
   localparam int PCW       = $clog2(DEPTH),
   localparam int NREG      = 1 << RSEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 pgm_we,
   input  logic [PCW-1:0]       pgm_addr,
   input  logic [WORD_W-1:0]    pgm_data,
   output logic [DW-1:0]        disp_value,
   output logic [NPORTS*DW-1:0] port_bus
);

   localparam logic [PCW-1:0] LAST = PCW'(DEPTH - 1);

   initial begin
      chk_depth_pow2: assert ((1 << PCW) == DEPTH)
         else $error("DEPTH must be a power of two");
      chk_target_fits: assert (PCW >= K_W)
         else $error("program counter narrower than jump constant");
      chk_ports_fit: assert (NPORTS >= 1 && NPORTS <= (1 << RSEL_W))
         else $error("NPORTS out of range for the port field");
      chk_width: assert (DW >= K_W)
         else $error("DW narrower than constant field");
   end

   logic [PCW-1:0]    pc_q;
   logic              halted_q;
   logic [WORD_W-1:0] word;
   logic [OP_W-1:0]   f_op;
   logic [RSEL_W-1:0] f_a, f_b;
   logic [K_W-1:0]    f_k;
   ctl_t              ctl;
   logic [DW-1:0]     val_a, val_b, alu_res;
   logic              a_zero, step, take;

   nib_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (pgm_we),
      .waddr (pgm_addr),
      .wdata (pgm_data),
      .raddr (pc_q),
      .rdata (word)
   );

   assign {f_op, f_a, f_b, f_k} = word;
   assign ctl  = decode_op(f_op);
   assign step = run && !halted_q;

   nib_regfile #(.DW(DW), .NREG(NREG), .CLEAR_RST(CLEAR_RST)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (step && ctl.reg_we),
      .waddr  (f_a),
      .wdata  (alu_res),
      .addr_a (f_a),
      .addr_b (f_b),
      .data_a (val_a),
      .data_b (val_b)
   );

   nib_alu #(.DW(DW), .KW(K_W)) u_alu (
      .a      (val_a),
      .b      (val_b),
      .k      (f_k),
      .fn     (ctl.fn),
      .result (alu_res),
      .a_zero (a_zero)
   );

   nib_ports #(.DW(DW), .NPORTS(NPORTS), .SELW(RSEL_W)) u_ports (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (step && ctl.port_we),
      .sel   (f_b),
      .data  (val_a),
      .bus   (port_bus)
   );

   assign disp_value = port_bus[DW-1:0];
   assign take       = ctl.br_always || (ctl.br_zero && a_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         halted_q <= 1'b0;
      end else if (step) begin
         if (pc_q == LAST) halted_q <= 1'b1;
         else if (take)    pc_q     <= PCW'(f_k);
         else              pc_q     <= pc_q + 1'b1;
      end
   end

   assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pc_q));

   assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> halted_q && $stable(pc_q));

   assert_goto_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ctl.br_always && pc_q != LAST) |=> pc_q == PCW'($past(f_k)));

   assert_brz_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && ctl.br_zero && val_a == '0 && pc_q != LAST) |=> pc_q == PCW'($past(f_k)));

   assert_fallthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ctl.br_always && !ctl.br_zero && pc_q != LAST) |=> pc_q == $past(pc_q) + 1'b1);

endmodule

// File: tb/test_nib_core.sv
module test_nib_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic        pgm_we = 1'b0;
   logic [4:0]  pgm_addr = '0;
   logic [15:0] pgm_data = '0;
   logic [15:0] disp_value;
   logic [63:0] port_bus;

   int checks = 0;
   int errors = 0;
   logic [15:0] img [32];

   always #5 clk = ~clk;

   nib_core i_nib_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .pgm_we     (pgm_we),
      .pgm_addr   (pgm_addr),
      .pgm_data   (pgm_data),
      .disp_value (disp_value),
      .port_bus   (port_bus)
   );

   function automatic logic [15:0] port(input int i);
      return port_bus[i*16 +: 16];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      run   = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load_img();
      for (int a = 0; a < 32; a++) begin
         @(negedge clk);
         pgm_we   = 1'b1;
         pgm_addr = 5'(a);
         pgm_data = img[a];
      end
      @(negedge clk);
      pgm_we = 1'b0;
   endtask

   task automatic clear_img();
      for (int a = 0; a < 32; a++) img[a] = 16'h0000;
   endtask

   task automatic img_countup();
      clear_img();
      img[0] = 16'h2001; img[1] = 16'h1100; img[2] = 16'hC100; img[3] = 16'hF001;
   endtask

   initial begin
      int v;
      // reset state
      repeat (3) @(negedge clk);
      for (int p = 0; p < 4; p++) check("R7 reset port", 32'(port(p)), 32'h0);
      check("R7 reset display", 32'(disp_value), 32'h0);
      rst_n = 1'b1;

      // count-up loop: display after edge n is n/3
      img_countup();
      load_img();
      repeat (4) @(negedge clk);
      check("R8 idle before run", 32'(disp_value), 32'h0);
      run = 1'b1;
      for (int n = 1; n <= 30; n++) begin
         @(negedge clk);
         check("R1 R2 R4 R6 count-up", 32'(disp_value), 32'(n / 3));
      end
      run = 1'b0;
      v = int'(disp_value);
      for (int n = 0; n < 8; n++) begin
         @(negedge clk);
         check("R8 paused", 32'(disp_value), 32'(v));
      end
      run = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 resume", 32'(disp_value), 32'(v + 1));

      // count-down from 9, then filler no-ops, then stop at address 31
      do_reset();
      clear_img();
      img[0] = 16'h2001; img[1] = 16'h2109; img[2] = 16'hC100; img[3] = 16'h3100;
      img[4] = 16'hD106; img[5] = 16'hF002; img[6] = 16'hC100;
      img[10] = 16'h7300; img[11] = 16'hE30F; img[12] = 16'h4300;
      img[13] = 16'h9300; img[14] = 16'hA300; img[15] = 16'hB300;
      img[16] = 16'h5300; img[17] = 16'h6300; img[18] = 16'h8300;
      img[29] = 16'h2205; img[30] = 16'h1320; img[31] = 16'hC310;
      load_img();
      run = 1'b1;
      for (int n = 1; n <= 63; n++) begin
         int e;
         @(negedge clk);
         if (n < 3)        e = 0;
         else if (n <= 35) e = 9 - (n - 3) / 4;
         else if (n <= 37) e = 1;
         else              e = 0;
         check("R3 R5 count-down", 32'(disp_value), 32'(e));
      end
      check("R10 unimplemented codes wrote nothing", 32'(port(1)), 32'h5);
      repeat (40) @(negedge clk);
      check("R9 stopped display", 32'(disp_value), 32'h0);
      check("R9 stopped port1", 32'(port(1)), 32'h5);

      // ports, constant zero-extension, subtract wrap, branch not taken
      do_reset();
      clear_img();
      img[0] = 16'h260F; img[1] = 16'h1660; img[2] = 16'h2602; img[3] = 16'hC610;
      img[4] = 16'h2001; img[5] = 16'h3700; img[6] = 16'hC720; img[7] = 16'hC790;
      img[8] = 16'hD70B; img[9] = 16'h2503; img[10] = 16'hC530; img[11] = 16'hF00B;
      load_img();
      run = 1'b1;
      repeat (20) @(negedge clk);
      check("R4 port0 untouched", 32'(port(0)), 32'h0);
      check("R1 zero-extended constant", 32'(port(1)), 32'h2);
      check("R3 wrap to 0xFFFF", 32'(port(2)), 32'hFFFF);
      check("R5 not taken on nonzero", 32'(port(3)), 32'h3);

      // store write colliding with execution of address 0
      do_reset();
      img_countup();
      load_img();
      @(negedge clk);
      run      = 1'b1;
      pgm_we   = 1'b1;
      pgm_addr = 5'd0;
      pgm_data = 16'h2007;
      @(negedge clk);
      pgm_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R11 old word executed", 32'(disp_value), 32'h1);
      repeat (3) @(negedge clk);
      check("R11 old word step 2", 32'(disp_value), 32'h2);
      do_reset();
      run = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 R7 new word after reset", 32'(disp_value), 32'h7);
      repeat (3) @(negedge clk);
      check("R11 new word step 2", 32'(disp_value), 32'hE);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule